// File: doc/BRIEF.md
# Shared-Cable Path Direction Controller

This block drives the select line of the single-pole double-throw switch at one end of a coaxial cable. The cable is shared in time. It carries the integration pulse from the acquisition side out to the sensor head. It then carries the line-sensor video back over the same conductor. One instance sits at each end of the cable. Both instances receive the same integration pulse and the same pixel-rate tick, so their switch selects change together.

The select rests on the control path. A falling edge of the integration pulse, taken through a two-flop synchronizer, opens the video window and clears the pixel counter. Every pixel tick inside the window advances the counter. When the count reaches the selected end value, the select returns to the control path and a single-cycle done strobe is raised. The end value is either the full line (`FULL_COUNT`, 5076 by default, which includes the trailing dummy pixels) or the short line (`SHORT_COUNT`, 5064 by default, which excludes them). The choice is taken at the moment the window opens.

The synchronizer adds a fixed, small delay. The line starts with 64 dummy pixels, so the switch always settles before the first exposure pixel. None of the pins carries streamed data, so there is no valid/ready handshake. Every pin is a plain level or a one-cycle strobe.

Top module: `cable_dir_ctrl`

## Requirements
- R1: After reset, `path_video_o` is 0 (control path), `window_done_o` is 0, `overrun_o` is 0 and `pix_count_o` is 0.
- R2: When `integ_pulse_i` falls while the window is closed, `path_video_o` becomes 1 on the third rising clock edge after the change, and `pix_count_o` is 0 at that point.
- R3: A rising edge of `integ_pulse_i`, or a steady level, never opens the window.
- R4: With `end_full_i` = 1 sampled at opening, the window closes on the clock edge that takes the `FULL_COUNT`-th pixel tick. On that edge `path_video_o` returns to 0 and `pix_count_o` returns to 0.
- R5: With `end_full_i` = 0 sampled at opening, the window closes on the edge that takes the `SHORT_COUNT`-th pixel tick.
- R6: `end_full_i` is sampled only on the opening edge. Changes while the window is open have no effect on where it closes.
- R7: `window_done_o` is high for exactly one cycle, starting on the edge where `path_video_o` returns to 0, and at no other time.
- R8: A falling edge of `integ_pulse_i` while the window is open sets `overrun_o`, which stays set until reset. It does not restart or alter the count, and the window closes at its original end.
- R9: Each pixel tick inside the window raises `pix_count_o` by one. Ticks while the window is closed, and a tick on the opening edge, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| integ_pulse_i | input | 1 | Integration pulse, asynchronous; its falling edge opens a window |
| pix_tick_i | input | 1 | One-cycle strobe per pixel period |
| end_full_i | input | 1 | 1: close at FULL_COUNT, 0: close at SHORT_COUNT; taken at opening |
| path_video_o | output | 1 | Switch select: 1 video path, 0 control path |
| window_done_o | output | 1 | One-cycle strobe when the select returns to control |
| overrun_o | output | 1 | Sticky: a pulse edge arrived during an open window |
| pix_count_o | output | $clog2(FULL_COUNT+1) | Pixel ticks counted in the current window |

## Verification
The bench builds the controller with `FULL_COUNT` = 20 and `SHORT_COUNT` = 16. This gives a 5-bit counter. Both end counts, the count just before each end, and a mid-window change of the end select can then be reached in a few hundred cycles rather than tens of thousands. `SYNC_STAGES` stays at 2, so the opening latency of three edges is checked exactly as the default build uses it.

// File: rtl/cable_dir_pkg.sv
package cable_dir_pkg;

  typedef enum logic {
    PATH_CTRL  = 1'b0,
    PATH_VIDEO = 1'b1
  } path_e;

endpackage

// File: rtl/cable_pulse_sync.sv
module cable_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cable_fall_detect.sv
module cable_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;

  // R3: a fall strobe never lasts two cycles
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R3

endmodule

// File: rtl/cable_window_ctr.sv
module cable_window_ctr
  import cable_dir_pkg::*;
#(
  parameter int FULL_COUNT  = 5076,
  parameter int SHORT_COUNT = 5064,
  localparam int CNT_W      = $clog2(FULL_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             end_full_i,
  output path_e            path_o,
  output logic             done_o,
  output logic             overrun_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LIM_FULL  = CNT_W'(FULL_COUNT);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_COUNT);

  path_e            path_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             done_q;
  logic             ovr_q;
  logic             last_tick;

  assign last_tick = tick_i && (count_q == limit_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q  <= PATH_CTRL;
      count_q <= '0;
      limit_q <= LIM_FULL;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (path_q == PATH_CTRL) begin
        if (fall_i) begin
          path_q  <= PATH_VIDEO;
          count_q <= '0;
          limit_q <= end_full_i ? LIM_FULL : LIM_SHORT;
        end
      end else begin
        if (fall_i) ovr_q <= 1'b1;
        if (last_tick) begin
          path_q  <= PATH_CTRL;
          count_q <= '0;
          done_q  <= 1'b1;
        end else if (tick_i) begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  assign path_o    = path_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;
  assign count_o   = count_q;

  AST_OPEN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_CTRL && fall_i) |=> (path_q == PATH_VIDEO && count_q == '0)); // R2

  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_VIDEO) |-> (count_q < limit_q)); // R4

  AST_CLOSE_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(path_q) == PATH_VIDEO && path_q == PATH_CTRL) |->
      ($past(tick_i) && $past(count_q) == $past(limit_q) - 1'b1)); // R5

  AST_LIMIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_VIDEO && $past(path_q) == PATH_VIDEO) |-> $stable(limit_q)); // R6

  AST_DONE_WITH_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (path_q == PATH_CTRL && $past(path_q) == PATH_VIDEO)); // R7

  AST_OVERRUN_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_VIDEO && fall_i && !tick_i) |=> (path_q == PATH_VIDEO && $stable(count_q) && ovr_q)); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q); // R8

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_CTRL) |-> (count_q == '0)); // R9

endmodule

// File: rtl/cable_dir_ctrl.sv
module cable_dir_ctrl
  import cable_dir_pkg::*;
#(
  parameter int FULL_COUNT  = 5076,
  parameter int SHORT_COUNT = 5064,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FULL_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             integ_pulse_i,
  input  logic             pix_tick_i,
  input  logic             end_full_i,
  output logic             path_video_o,
  output logic             window_done_o,
  output logic             overrun_o,
  output logic [CNT_W-1:0] pix_count_o
);

  logic  pulse_sync;
  logic  pulse_fall;
  path_e path_sel;

  cable_pulse_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (integ_pulse_i),
    .sync_o  (pulse_sync)
  );

  cable_fall_detect u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pulse_sync),
    .fall_o  (pulse_fall)
  );

  cable_window_ctr #(
    .FULL_COUNT  (FULL_COUNT),
    .SHORT_COUNT (SHORT_COUNT)
  ) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (pulse_fall),
    .tick_i     (pix_tick_i),
    .end_full_i (end_full_i),
    .path_o     (path_sel),
    .done_o     (window_done_o),
    .overrun_o  (overrun_o),
    .count_o    (pix_count_o)
  );

  assign path_video_o = (path_sel == PATH_VIDEO);

  AST_RESET_TO_CTRL: assert property (@(posedge clk_i)
    !rst_ni |=> (!path_video_o && !overrun_o && !window_done_o)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_done_o |=> !window_done_o); // R7

endmodule

// File: tb/cable_dir_ctrl_tb.sv
module cable_dir_ctrl_tb;

  localparam int FULL  = 20;
  localparam int SHORT = 16;
  localparam int CW    = $clog2(FULL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic integ = 1'b1;
  logic tick = 1'b0;
  logic sel = 1'b1;
  logic path, done, ovr;
  logic [CW-1:0] cnt;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cable_dir_ctrl #(
    .FULL_COUNT  (FULL),
    .SHORT_COUNT (SHORT),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .integ_pulse_i (integ),
    .pix_tick_i    (tick),
    .end_full_i    (sel),
    .path_video_o  (path),
    .window_done_o (done),
    .overrun_o     (ovr),
    .pix_count_o   (cnt)
  );

  // vector: [11] end select, [10:6] ticks after opening, [5] expected path, [4:0] expected count
  localparam logic [11:0] VEC [6] = '{
    {1'b1, 5'd0,  1'b1, 5'd0},
    {1'b1, 5'd19, 1'b1, 5'd19},
    {1'b1, 5'd20, 1'b0, 5'd0},
    {1'b0, 5'd15, 1'b1, 5'd15},
    {1'b0, 5'd16, 1'b0, 5'd0},
    {1'b1, 5'd7,  1'b1, 5'd7}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic done_seen;

  task automatic pix_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    done_seen = done;
  endtask

  task automatic open_win(input logic s);
    @(negedge clk) begin sel = s; integ = 1'b1; end
    repeat (4) @(negedge clk);
    integ = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && path; i++) pix_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 path", path, 0);
    check("R1 done", done, 0);
    check("R1 overrun", ovr, 0);
    check("R1 count", cnt, 0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      open_win(VEC[v][11]);
      for (int t = 0; t < int'(VEC[v][10:6]); t++) pix_tick();
      check($sformatf("R4/R5/R9 vec%0d path", v), path, int'(VEC[v][5]));
      check($sformatf("R4/R5/R9 vec%0d count", v), cnt, int'(VEC[v][4:0]));
      drain();
    end

    // R2 exact latency
    @(negedge clk) begin sel = 1'b1; integ = 1'b1; end
    repeat (4) @(negedge clk);
    integ = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 not yet open after two edges", path, 0);
    @(negedge clk);
    check("R2 open after three edges", path, 1);
    check("R2 count cleared", cnt, 0);
    drain();

    // R3 rising edge and steady level
    @(negedge clk) integ = 1'b0;
    repeat (5) @(negedge clk);
    integ = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 rise ignored", path, 0);

    // R9 ticks while closed ignored
    pix_tick(); pix_tick();
    check("R9 idle ticks", cnt, 0);
    check("R9 idle path", path, 0);

    // R9 tick on opening edge ignored: tick coincides with third edge
    @(negedge clk) begin sel = 1'b1; integ = 1'b1; end
    repeat (4) @(negedge clk);
    integ = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R9 opening tick ignored", cnt, 0);
    check("R9 opened", path, 1);
    drain();

    // R7 done pulse width, R4 close
    open_win(1'b1);
    for (int t = 0; t < FULL - 1; t++) pix_tick();
    check("R7 done low before close", done_seen, 0);
    pix_tick();
    check("R7 done on close", done_seen, 1);
    check("R4 path closed", path, 0);
    @(negedge clk);
    check("R7 done one cycle", done, 0);

    // R6 end select change mid-window
    open_win(1'b0);
    sel = 1'b1;
    for (int t = 0; t < SHORT; t++) pix_tick();
    check("R6 short limit kept", path, 0);
    open_win(1'b1);
    sel = 1'b0;
    for (int t = 0; t < SHORT; t++) pix_tick();
    check("R6 full limit kept", path, 1);
    drain();

    // R8 overrun
    open_win(1'b1);
    for (int t = 0; t < 5; t++) pix_tick();
    check("R8 no overrun yet", ovr, 0);
    @(negedge clk) integ = 1'b1;
    repeat (4) @(negedge clk);
    integ = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 overrun set", ovr, 1);
    check("R8 count not restarted", cnt, 5);
    check("R8 still open", path, 1);
    for (int t = 0; t < FULL - 6; t++) pix_tick();
    check("R8 open before original end", path, 1);
    pix_tick();
    check("R8 closes at original end", path, 0);
    repeat (3) @(negedge clk);
    check("R8 overrun sticky", ovr, 1);

    // R1 reset clears overrun
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 overrun cleared", ovr, 0);
    check("R1 path after reset", path, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule